// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register RAM

This block is a byte-wide memory with a static-RAM style access port: an active-low chip enable, output enable and write enable, an address and an 8-bit data path. The port is sampled on a system clock. Writes take effect at the clock edge, and reads pass combinationally from the address to the output. The eight highest addresses hold a host-visible copy of a calendar clock. The calendar counter runs outside this block. It presents its current count on a snapshot bus and accepts new values through a load strobe. Host reads and writes touch only the visible copy, so they never disturb the running count.

A control byte at the lowest of the eight clock addresses holds two bits that manage transfers between the two copies. A freeze bit stops the refresh so that the host can read a stable time. A set bit stops the refresh as well, and when the host clears it the host's values are pushed to the counter. The seconds byte carries a bit that stops the oscillator. The day byte carries a frequency-test bit. While that bit is set and the oscillator runs, a 512 Hz square wave appears on the seconds LSB when the host reads it. A power-fail input blocks every access and drives an active-low warning output.

Top module: `timekeep_ram`

## Requirements
- R1: Clock byte index i (address = top-of-memory minus 7 plus i) maps as 0 control, 1 seconds, 2 minutes, 3 hour, 4 day, 5 date, 6 month, 7 year. Snapshot byte i-1 (bits 8(i-1)+7..8(i-1)) feeds index i.
- R2: If neither control bit 6 nor control bit 7 is set, a cycle with tick1Hz high copies the snapshot clock fields into the visible bytes. This copy is skipped in a cycle in which the host writes any clock address.
- R3: While control bit 6 (freeze) is 1, the visible clock bytes keep their values on ticks. The first tick after the bit is cleared refreshes all of them together.
- R4: While control bit 7 (set) is 1, ticks do not refresh. A host write to the control byte that changes bit 7 from 1 to 0 raises calLoad for exactly the next cycle. In that cycle calLoadVal carries visible bytes 1..7 packed in the R1 layout.
- R5: Seconds byte bit 7 is the stop bit and is presented on oscStop.
- R6: Refresh overwrites only the clock fields: masks 7F seconds, 7F minutes, 3F hour, 07 day, 3F date, 1F month, FF year. Every other bit of the eight bytes, and all bits of the control byte, keeps its written value like RAM.
- R7: If day bit 6 is 1 and the stop bit is 0, a read of the seconds byte returns sq512 on bit 0. Otherwise bit 0 returns the stored value.
- R8: A write occurs at the clock edge when ceN and weN are low. dOe is high only when ceN and oeN are low and weN is high, and dOut then shows the addressed byte.
- R9: While powerFail is high, no write occurs, dOe stays low and pfoN is low. pfoN is high otherwise.
- R10: After reset every byte reads 0, and calLoad and oscStop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dIn | input | 8 | Write data |
| dOut | output | 8 | Read data, zero when not driven |
| dOe | output | 1 | Data bus drive enable |
| powerFail | input | 1 | Supply out of tolerance |
| pfoN | output | 1 | Power-fail warning, active low |
| tick1Hz | input | 1 | One-cycle pulse per second from the counter |
| sq512 | input | 1 | 512 Hz square wave |
| calSnap | input | 56 | Running count from the calendar counter |
| calLoad | output | 1 | Load strobe to the calendar counter |
| calLoadVal | output | 56 | Values to load |
| oscStop | output | 1 | Stop request to the oscillator and counter |

## Verification
The assertions check on every cycle that a frozen visible copy stays put unless the host writes it. They also check that the load strobe appears only on a 1-to-0 change of the set bit, that spare hour bits change only on a host write, and that the bus is never driven during a write or a power failure. Only the bench scenarios can show the following: that snapshot bytes land in the right addresses with the right masks, that the refresh catches up on the first tick after the freeze is released, that a write to a clock address suppresses a concurrent tick, that the loaded values are correct, and how the frequency-test bit interacts with the stop bit.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int CLK_REGS = 8;
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SEC = 3'd1;
  localparam logic [2:0] IDX_HOUR = 3'd3;
  localparam logic [2:0] IDX_DAY = 3'd4;
  localparam int BIT_FREEZE = 6;
  localparam int BIT_SET = 7;
  localparam int BIT_STOP = 7;
  localparam int BIT_FTEST = 6;

  typedef struct packed {
    logic ramWe;
    logic clkWe;
    logic [2:0] clkIdx;
    logic refresh;
    logic loadGo;
    logic drive;
  } strobe_t;

  function automatic logic [7:0] fieldMask(input logic [2:0] idx);
    case (idx)
      3'd1, 3'd2: fieldMask = 8'h7F;
      3'd3, 3'd5: fieldMask = 8'h3F;
      3'd4: fieldMask = 8'h07;
      3'd6: fieldMask = 8'h1F;
      3'd7: fieldMask = 8'hFF;
      default: fieldMask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              powerFail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dIn,
  input  logic [7:0]        ctrlByte,
  input  logic              tick1Hz,
  output strobe_t           st
);
  logic selected;
  logic writeCyc;
  logic inClock;

  always_comb begin
    selected = !ceN && !powerFail;
    writeCyc = selected && !weN;
    inClock = &addr[ADDR_W-1:3];
    st.ramWe = writeCyc && !inClock;
    st.clkWe = writeCyc && inClock;
    st.clkIdx = addr[2:0];
    st.drive = selected && !oeN && weN;
    st.refresh = tick1Hz && !ctrlByte[BIT_FREEZE] && !ctrlByte[BIT_SET] && !st.clkWe;
    st.loadGo = st.clkWe && (addr[2:0] == IDX_CTRL) && ctrlByte[BIT_SET] && !dIn[BIT_SET];
  end
endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import tk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dIn,
  input  logic [55:0]       calSnap,
  input  logic              sq512,
  output logic [7:0]        dOut,
  output logic              dOe,
  output logic [7:0]        ctrlByte,
  output logic              calLoad,
  output logic [55:0]       calLoadVal,
  output logic              oscStop
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LOW_DEPTH = DEPTH - CLK_REGS;

  logic [7:0] ram [LOW_DEPTH];
  logic [7:0] usr [CLK_REGS];
  logic [55:0] usrPacked;
  logic [7:0] rdByte;
  logic inClock;

  always_comb begin
    for (int k = 1; k < CLK_REGS; k++) usrPacked[8*(k-1) +: 8] = usr[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < LOW_DEPTH; k++) ram[k] <= '0;
      for (int k = 0; k < CLK_REGS; k++) usr[k] <= '0;
      calLoad <= 1'b0;
      calLoadVal <= '0;
    end else begin
      if (st.ramWe) ram[addr] <= dIn;
      for (int k = 0; k < CLK_REGS; k++) begin
        if (st.clkWe && st.clkIdx == 3'(k))
          usr[k] <= dIn;
        else if (st.refresh)
          usr[k] <= (usr[k] & ~fieldMask(3'(k))) | (calSnap[8*((k+7)%8) +: 8] & fieldMask(3'(k)));
      end
      calLoad <= st.loadGo;
      if (st.loadGo) calLoadVal <= usrPacked;
    end
  end

  always_comb begin
    inClock = &addr[ADDR_W-1:3];
    rdByte = inClock ? usr[addr[2:0]] : ram[addr];
    if (inClock && addr[2:0] == IDX_SEC && usr[IDX_DAY][BIT_FTEST] && !usr[IDX_SEC][BIT_STOP])
      rdByte[0] = sq512;
    dOe = st.drive;
    dOut = st.drive ? rdByte : 8'h00;
    ctrlByte = usr[IDX_CTRL];
    oscStop = usr[IDX_SEC][BIT_STOP];
  end

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(usr[IDX_CTRL][BIT_FREEZE] | usr[IDX_CTRL][BIT_SET]) && !$past(st.clkWe)) |-> $stable(usrPacked));

  // R4
  load_on_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    calLoad |-> ($past(usr[IDX_CTRL][BIT_SET]) && !usr[IDX_CTRL][BIT_SET]));

  // R6
  spare_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.clkWe) |-> $stable(usr[IDX_HOUR][7:6]));
endmodule

// File: rtl/timekeep_ram.sv
module timekeep_ram
  import tk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dIn,
  output logic [7:0]        dOut,
  output logic              dOe,
  input  logic              powerFail,
  output logic              pfoN,
  input  logic              tick1Hz,
  input  logic              sq512,
  input  logic [55:0]       calSnap,
  output logic              calLoad,
  output logic [55:0]       calLoadVal,
  output logic              oscStop
);
  strobe_t st;
  logic [7:0] ctrlByte;

  tk_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .ceN(ceN), .oeN(oeN), .weN(weN), .powerFail(powerFail), .addr(addr),
    .dIn(dIn), .ctrlByte(ctrlByte), .tick1Hz(tick1Hz), .st(st)
  );

  tk_datapath #(.ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .st(st), .addr(addr), .dIn(dIn), .calSnap(calSnap),
    .sq512(sq512), .dOut(dOut), .dOe(dOe), .ctrlByte(ctrlByte), .calLoad(calLoad),
    .calLoadVal(calLoadVal), .oscStop(oscStop)
  );

  assign pfoN = !powerFail;

  // R9
  pf_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !dOe);

  // R8
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dOe |-> (weN && !oeN && !ceN));
endmodule

// File: tb/timekeep_ram_test.sv
module timekeep_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 0;
  logic rstN = 0;
  logic ceN = 1, oeN = 1, weN = 1, powerFail = 0, tick1Hz = 0, sq512 = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dIn = '0;
  logic [55:0] calSnap = '0;
  logic [7:0] dOut;
  logic dOe, pfoN, calLoad, oscStop;
  logic [55:0] calLoadVal;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] mm [32];
  logic expLoad;
  logic [55:0] expLoadVal;

  timekeep_ram #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOe(dOe), .powerFail(powerFail), .pfoN(pfoN), .tick1Hz(tick1Hz),
    .sq512(sq512), .calSnap(calSnap), .calLoad(calLoad), .calLoadVal(calLoadVal),
    .oscStop(oscStop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] maskOf(input int i);
    case (i)
      1, 2: return 8'h7F;
      3, 5: return 8'h3F;
      4: return 8'h07;
      6: return 8'h1F;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic drive;
    logic [7:0] rb;
    logic wr, rf, ld;
    #1;
    drive = !ceN && !powerFail && !oeN && weN;
    check(tag, "dOe", dOe, drive);
    check(tag, "pfoN", pfoN, !powerFail);
    check(tag, "oscStop", oscStop, mm[25][7]);
    check(tag, "calLoad", calLoad, expLoad);
    if (expLoad) check(tag, "calLoadVal", calLoadVal, expLoadVal);
    if (drive) begin
      rb = mm[addr];
      if (addr == 25 && mm[28][6] && !mm[25][7]) rb[0] = sq512;
      check(tag, "dOut", dOut, rb);
    end
    @(posedge clk);
    wr = !ceN && !powerFail && !weN;
    rf = tick1Hz && !mm[24][7] && !mm[24][6] && !(wr && addr >= 24);
    ld = wr && addr == 24 && mm[24][7] && !dIn[7];
    if (ld) for (int k = 1; k < 8; k++) expLoadVal[8*(k-1) +: 8] = mm[24+k];
    expLoad = ld;
    if (wr) mm[addr] = dIn;
    else if (rf) for (int k = 1; k < 8; k++)
      mm[24+k] = (mm[24+k] & ~maskOf(k)) | (calSnap[8*(k-1) +: 8] & maskOf(k));
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag);
    ceN = 0; oeN = 0; weN = 1; addr = AW'(a); step(tag);
    ceN = 1; oeN = 1;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    ceN = 0; oeN = 1; weN = 0; addr = AW'(a); dIn = d; step(tag);
    ceN = 1; weN = 1;
  endtask

  task automatic tick(input string tag);
    tick1Hz = 1; step(tag); tick1Hz = 0;
  endtask

  task automatic readClock(input string tag);
    for (int a = 24; a < 32; a++) rd(a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) mm[k] = 8'h00;
    expLoad = 0; expLoadVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 reset state
    for (int a = 0; a < 32; a++) rd(a, "R10");
    // R8 plain RAM patterns
    for (int a = 0; a < 24; a++) wr(a, 8'(a * 37 + 5), "R8");
    for (int a = 0; a < 24; a++) rd(a, "R8");
    wr(3, 8'hAA, "R8"); rd(3, "R8");
    ceN = 1; weN = 0; addr = 5; dIn = 8'h11; step("R8"); weN = 1; rd(5, "R8");
    ceN = 0; oeN = 1; weN = 1; addr = 5; step("R8"); ceN = 1;
    // R1 R2 refresh into address map
    calSnap = 56'h99_12_31_07_23_59_58;
    tick("R2"); readClock("R1");
    // R6 spare bits survive refresh
    wr(27, 8'hC5, "R6"); wr(30, 8'hE3, "R6");
    calSnap = 56'h24_02_29_05_11_22_33;
    tick("R6"); readClock("R6");
    // R2 tick during clock write suppressed
    calSnap = 56'h01_01_01_01_01_01_01;
    tick1Hz = 1; wr(31, 8'h42, "R2"); tick1Hz = 0;
    readClock("R2");
    // R3 freeze
    wr(24, 8'h40, "R3");
    calSnap = 56'h55_05_15_03_10_20_30;
    tick("R3"); readClock("R3");
    wr(24, 8'h00, "R3"); readClock("R3");
    tick("R3"); readClock("R3");
    // R4 set bit and load
    wr(24, 8'h80, "R4");
    wr(26, 8'h45, "R4"); wr(27, 8'h17, "R4"); wr(31, 8'h30, "R4");
    calSnap = 56'h77_07_07_07_07_07_07;
    tick("R4"); readClock("R4");
    wr(24, 8'h00, "R4"); rd(26, "R4"); rd(26, "R4");
    wr(24, 8'h00, "R4"); rd(26, "R4");
    // R5 stop bit
    wr(25, 8'h80, "R5"); rd(25, "R5");
    tick("R5"); rd(25, "R5");
    // R7 frequency test
    wr(28, 8'h44, "R7");
    sq512 = 1; rd(25, "R7"); sq512 = 0; rd(25, "R7");
    wr(25, 8'h21, "R7");
    sq512 = 0; rd(25, "R7"); sq512 = 1; rd(25, "R7");
    wr(28, 8'h04, "R7"); sq512 = 0; rd(25, "R7");
    // R9 power fail
    powerFail = 1;
    wr(7, 8'h5A, "R9"); wr(31, 8'h5A, "R9"); rd(7, "R9"); tick("R9");
    powerFail = 0;
    rd(7, "R9"); readClock("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule